// File: doc/BRIEF.md
# FSK Bit Clock and Data Synchronizer

This block sits between a transmit host and a two-level FSK modulator. From the reference clock it derives a modulator clock, one strobe every K reference cycles, with K a programmable 6-bit integer. A power-of-two stage then divides that strobe by 2^(3+n) to form the bit clock. When the synchronous data interface is on, the bit clock leaves the block as a square data clock. The host updates its data after each falling edge, and the block captures the data on each rising edge. When the interface is off, the data clock stays low and the host's data goes straight through to the modulator.

The block also feeds the frequency synthesizer. It holds two complete divider sets, each made of a 12-bit reference divider, a 12-bit feedback divider and a 6-bit swallow count. In the divider-switching modulation mode the current transmit bit chooses which set the synthesizer receives. In the two VCO-pulling modes, and for the unused code, set 0 is always presented.

Top module: `fsk_bitsync`

## Requirements
- R1: `mod_tick` is high for one cycle in every Keff reference cycles, where Keff is `div_k`, except that `div_k` = 0 is used as 1.
- R2: With `sync_en` = 1, `dclk` has a period of Keff * 2^(3+neff) reference cycles and is high for exactly half of each period. neff is `pow_n`, clamped to 5 when `pow_n` is above 5.
- R3: `bit_stb` is high for exactly one cycle per `dclk` period, in the first cycle that `dclk` reads high.
- R4: With `sync_en` = 1, `tx_bit` takes the value that `data_in` has when `dclk` rises, and it appears within two cycles of the rise. A change of `data_in` while `dclk` is low does not alter `tx_bit` until the next rise.
- R5: With `sync_en` = 0, `dclk` and `bit_stb` stay low, and `tx_bit` equals `data_in` in the same cycle.
- R6: When `mod_mode` is 2'b00 (closed-loop VCO), 2'b01 (open-loop VCO) or 2'b11 (unused), the outputs `syn_m`, `syn_n` and `syn_a` carry set 0 (`m0`, `n0`, `a0`) whatever `tx_bit` is.
- R7: When `mod_mode` is 2'b10 (divider switching), `tx_bit` = 0 presents set 0 and `tx_bit` = 1 presents set 1 (`m1`, `n1`, `a1`).
- R8: While `rst_n` is low, `mod_tick`, `dclk`, `bit_stb` and, in synchronous mode, `tx_bit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_en | input | 1 | 1: drive data clock and sample data; 0: transparent data |
| mod_mode | input | 2 | Modulation mode code |
| div_k | input | 6 | Reference divider K (0 used as 1) |
| pow_n | input | 3 | Power-of-two exponent n (above 5 used as 5) |
| data_in | input | 1 | Transmit data from host |
| m0 | input | 12 | Divider set 0, reference divider |
| n0 | input | 12 | Divider set 0, feedback divider |
| a0 | input | 6 | Divider set 0, swallow count |
| m1 | input | 12 | Divider set 1, reference divider |
| n1 | input | 12 | Divider set 1, feedback divider |
| a1 | input | 6 | Divider set 1, swallow count |
| mod_tick | output | 1 | One-cycle modulator clock strobe |
| dclk | output | 1 | Data clock to host |
| bit_stb | output | 1 | One-cycle strobe on each data clock rise |
| tx_bit | output | 1 | Current bit to modulator |
| syn_m | output | 12 | Selected reference divider |
| syn_n | output | 12 | Selected feedback divider |
| syn_a | output | 6 | Selected swallow count |

## Verification
The hardest situation to reach is the host changing `data_in` during the low half of `dclk`. In that window the new value must not reach `tx_bit` early, and it must be taken at the next rise. The stimulus tracks `dclk` at the ports and waits for each falling edge before driving a new bit. It checks `tx_bit` right after the change and again just after the following rise. In divider-switching mode, the same sequence also steps the synthesizer outputs between the two sets. The clamp cases, `div_k` = 0 and `pow_n` = 7, are reached by measuring the strobe and clock periods at the outputs.

// File: rtl/fsk_bitsync_pkg.sv
// Shared widths and types for the FSK bit clock and data synchronizer.
package fsk_bitsync_pkg;

    localparam int MDIV_W = 12;
    localparam int NDIV_W = 12;
    localparam int ADIV_W = 6;

    typedef enum logic [1:0] {
        MODE_VCO_CLOSED = 2'b00,
        MODE_VCO_OPEN   = 2'b01,
        MODE_DIV_SWITCH = 2'b10,
        MODE_SPARE      = 2'b11
    } mod_mode_e;

    typedef struct packed {
        logic [MDIV_W-1:0] m;
        logic [NDIV_W-1:0] n;
        logic [ADIV_W-1:0] a;
    } div_set_t;

endpackage

// File: rtl/fsk_refdiv.sv
// Reference divider: emits a one-cycle strobe every Keff cycles.
// Assumes div_k may change at any time; a value of 0 is used as 1, and a
// count already past the new limit wraps on the next cycle.
module fsk_refdiv #(
    parameter int KW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [KW-1:0] div_k,
    output logic          tick
);
    logic [KW-1:0] cnt;
    logic [KW-1:0] k_eff;

    // Clamp the divide value to at least one.
    always_comb k_eff = (div_k == '0) ? KW'(1) : div_k;

    // Count reference cycles and strobe when the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= k_eff - KW'(1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + KW'(1);
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/fsk_bitdiv.sv
// Power-of-two divider on the modulator strobe: forms a 50% data clock of
// 2^(3+neff) strobes per period and a one-cycle strobe on each rise.
// Assumes pow_n above NMAX is clamped; held idle while sync is off.
module fsk_bitdiv #(
    parameter int NW   = 3,
    parameter int NMAX = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_en,
    input  logic          tick,
    input  logic [NW-1:0] pow_n,
    output logic          dclk,
    output logic          rise_stb
);
    localparam int CW = 3 + NMAX;

    logic [CW-1:0]   cnt;
    logic [CW-1:0]   cnt_nxt;
    logic [NW-1:0]   n_eff;
    logic [NMAX:0]   tap_hot;
    logic [NMAX:0]   wrap_hit;
    logic [NMAX:0]   phase_tap;
    logic            terminal;
    logic            phase_nxt;

    // Clamp the exponent to the largest supported stage.
    always_comb n_eff = (pow_n > NW'(NMAX)) ? NW'(NMAX) : pow_n;

    // One entry per supported exponent: selector, wrap point and phase tap.
    for (genvar g = 0; g <= NMAX; g++) begin : g_stage
        assign tap_hot[g]   = (n_eff == NW'(g));
        assign wrap_hit[g]  = &cnt[2+g:0];
        assign phase_tap[g] = cnt_nxt[2+g];
    end

    // Next count: wrap at the end of the selected period.
    always_comb begin
        terminal  = |(tap_hot & wrap_hit);
        cnt_nxt   = terminal ? '0 : cnt + CW'(1);
        phase_nxt = |(tap_hot & phase_tap);
    end

    // Advance on each modulator strobe; register clock and rise strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !sync_en) begin
            cnt      <= '0;
            dclk     <= 1'b0;
            rise_stb <= 1'b0;
        end else if (tick) begin
            cnt      <= cnt_nxt;
            dclk     <= phase_nxt;
            rise_stb <= phase_nxt & ~dclk;
        end else begin
            rise_stb <= 1'b0;
        end
    end
endmodule

// File: rtl/fsk_datasel.sv
// Data capture and divider-set selection. In synchronous mode the bit is
// captured on the rise strobe; otherwise data passes through unregistered.
// The divider set follows the bit only in divider-switching mode.
module fsk_datasel
    import fsk_bitsync_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sync_en,
    input  logic      rise_stb,
    input  logic      data_in,
    input  mod_mode_e mode,
    input  div_set_t  set0,
    input  div_set_t  set1,
    output logic      tx_bit,
    output div_set_t  sel_set
);
    logic bit_q;

    // Capture host data on each data clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n)        bit_q <= 1'b0;
        else if (rise_stb) bit_q <= data_in;
    end

    // Choose registered or transparent data, then the divider set.
    always_comb begin
        tx_bit  = sync_en ? bit_q : data_in;
        sel_set = set0;
        if (mode == MODE_DIV_SWITCH && tx_bit) sel_set = set1;
    end
endmodule

// File: rtl/fsk_bitsync.sv
// Top: modulator strobe, data clock, data capture and divider-set mux.
// Assumes one clock domain (the reference) and synchronous active-low reset.
module fsk_bitsync
    import fsk_bitsync_pkg::*;
#(
    parameter int KW   = 6,
    parameter int NW   = 3,
    parameter int NMAX = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_en,
    input  logic [1:0]        mod_mode,
    input  logic [KW-1:0]     div_k,
    input  logic [NW-1:0]     pow_n,
    input  logic              data_in,
    input  logic [MDIV_W-1:0] m0,
    input  logic [NDIV_W-1:0] n0,
    input  logic [ADIV_W-1:0] a0,
    input  logic [MDIV_W-1:0] m1,
    input  logic [NDIV_W-1:0] n1,
    input  logic [ADIV_W-1:0] a1,
    output logic              mod_tick,
    output logic              dclk,
    output logic              bit_stb,
    output logic              tx_bit,
    output logic [MDIV_W-1:0] syn_m,
    output logic [NDIV_W-1:0] syn_n,
    output logic [ADIV_W-1:0] syn_a
);
    div_set_t set0, set1, sel_set;

    // Pack the two divider sets.
    always_comb begin
        set0 = '{m: m0, n: n0, a: a0};
        set1 = '{m: m1, n: n1, a: a1};
    end

    fsk_refdiv #(.KW(KW)) refdiv_i (
        .clk   (clk),
        .rst_n (rst_n),
        .div_k (div_k),
        .tick  (mod_tick)
    );

    fsk_bitdiv #(.NW(NW), .NMAX(NMAX)) bitdiv_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_en  (sync_en),
        .tick     (mod_tick),
        .pow_n    (pow_n),
        .dclk     (dclk),
        .rise_stb (bit_stb)
    );

    fsk_datasel datasel_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_en  (sync_en),
        .rise_stb (bit_stb),
        .data_in  (data_in),
        .mode     (mod_mode_e'(mod_mode)),
        .set0     (set0),
        .set1     (set1),
        .tx_bit   (tx_bit),
        .sel_set  (sel_set)
    );

    // Unpack the selected set to the synthesizer outputs.
    always_comb begin
        syn_m = sel_set.m;
        syn_n = sel_set.n;
        syn_a = sel_set.a;
    end
endmodule

// File: rtl/fsk_bitsync_chk.sv
// Checker for fsk_bitsync, attached by bind; observes ports only.
module fsk_bitsync_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sync_en,
    input logic [1:0]  mod_mode,
    input logic        data_in,
    input logic [11:0] m0,
    input logic [11:0] n0,
    input logic [5:0]  a0,
    input logic [11:0] m1,
    input logic        mod_tick,
    input logic        dclk,
    input logic        bit_stb,
    input logic        tx_bit,
    input logic [11:0] syn_m,
    input logic [11:0] syn_n,
    input logic [5:0]  syn_a
);
    // R3
    stb_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> (dclk && !$past(dclk)));

    // R3
    stb_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> $past(mod_tick));

    // R5
    idle_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en |=> (!dclk && !bit_stb));

    // R5
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en |-> (tx_bit == data_in));

    // R6
    set0_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_mode != 2'b10) |-> (syn_m == m0 && syn_n == n0 && syn_a == a0));

    // R7
    set1_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_mode == 2'b10 && tx_bit) |-> (syn_m == m1));

    // R4
    hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && $past(sync_en) && !$past(bit_stb)) |-> $stable(tx_bit));
endmodule

bind fsk_bitsync fsk_bitsync_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_en  (sync_en),
    .mod_mode (mod_mode),
    .data_in  (data_in),
    .m0       (m0),
    .n0       (n0),
    .a0       (a0),
    .m1       (m1),
    .mod_tick (mod_tick),
    .dclk     (dclk),
    .bit_stb  (bit_stb),
    .tx_bit   (tx_bit),
    .syn_m    (syn_m),
    .syn_n    (syn_n),
    .syn_a    (syn_a)
);

// File: tb/fsk_bitsync_tb_top.sv
// Self-checking bench for fsk_bitsync.
module fsk_bitsync_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_en = 1'b0;
    logic [1:0]  mod_mode = 2'b00;
    logic [5:0]  div_k = 6'd1;
    logic [2:0]  pow_n = 3'd0;
    logic        data_in = 1'b0;
    logic [11:0] m0 = 12'h123, n0 = 12'h456, m1 = 12'hABC, n1 = 12'hDEF;
    logic [5:0]  a0 = 6'h07, a1 = 6'h38;
    logic        mod_tick, dclk, bit_stb, tx_bit;
    logic [11:0] syn_m, syn_n;
    logic [5:0]  syn_a;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fsk_bitsync dut_i (
        .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .mod_mode(mod_mode),
        .div_k(div_k), .pow_n(pow_n), .data_in(data_in),
        .m0(m0), .n0(n0), .a0(a0), .m1(m1), .n1(n1), .a1(a1),
        .mod_tick(mod_tick), .dclk(dclk), .bit_stb(bit_stb), .tx_bit(tx_bit),
        .syn_m(syn_m), .syn_n(syn_n), .syn_a(syn_a)
    );

    // Mux vectors: {mod_mode, data_in, expect set 1}
    localparam logic [3:0] MUX_VEC [8] = '{
        4'b00_0_0, 4'b00_1_0, 4'b01_0_0, 4'b01_1_0,
        4'b10_0_0, 4'b10_1_1, 4'b11_0_0, 4'b11_1_0
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure_tick(output int per);
        per = 0;
        do @(negedge clk); while (!mod_tick);
        do begin @(negedge clk); per++; end while (!mod_tick);
    endtask

    task automatic wait_rise();
        logic p;
        p = dclk;
        forever begin
            @(negedge clk);
            if (dclk && !p) break;
            p = dclk;
        end
    endtask

    task automatic wait_fall();
        logic p;
        p = dclk;
        forever begin
            @(negedge clk);
            if (!dclk && p) break;
            p = dclk;
        end
    endtask

    task automatic measure_dclk(output int per, output int hi,
                                output int stbs, output int stb_at_rise);
        logic p;
        wait_rise();
        per = 0; hi = 1; stbs = bit_stb ? 1 : 0; stb_at_rise = bit_stb ? 1 : 0;
        p = dclk;
        forever begin
            @(negedge clk);
            per++;
            if (dclk && !p) break;
            if (dclk) hi++;
            if (bit_stb) stbs++;
            p = dclk;
        end
    endtask

    task automatic dclk_case(input int k, input int n, input int exp_per);
        int per, hi, stbs, sr;
        div_k = 6'(k); pow_n = 3'(n);
        measure_dclk(per, hi, stbs, sr);
        measure_dclk(per, hi, stbs, sr);
        chk("R2 period", per, exp_per);
        chk("R2 duty", hi, exp_per / 2);
        chk("R3 one strobe", stbs, 1);
        chk("R3 strobe at rise", sr, 1);
    endtask

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int per;
        logic prev;
        // R8: reset state with sync mode on
        sync_en = 1'b1;
        data_in = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 mod_tick", mod_tick, 0);
        chk("R8 dclk", dclk, 0);
        chk("R8 bit_stb", bit_stb, 0);
        chk("R8 tx_bit", tx_bit, 0);
        sync_en = 1'b0;
        rst_n = 1'b1;

        // R6 R7: table of mode/data vectors, transparent data path
        for (int i = 0; i < 8; i++) begin
            mod_mode = MUX_VEC[i][3:2];
            data_in  = MUX_VEC[i][1];
            @(negedge clk);
            chk("R5 passthru", tx_bit, data_in);
            if (MUX_VEC[i][0]) begin
                chk("R7 m", syn_m, m1); chk("R7 n", syn_n, n1); chk("R7 a", syn_a, a1);
            end else begin
                chk("R6 m", syn_m, m0); chk("R6 n", syn_n, n0); chk("R6 a", syn_a, a0);
            end
        end

        // R1: modulator strobe period, including K=0 clamp
        div_k = 6'd5;  measure_tick(per); measure_tick(per); chk("R1 K=5", per, 5);
        div_k = 6'd1;  measure_tick(per); measure_tick(per); chk("R1 K=1", per, 1);
        div_k = 6'd0;  measure_tick(per); measure_tick(per); chk("R1 K=0", per, 1);
        div_k = 6'd63; measure_tick(per); measure_tick(per); chk("R1 K=63", per, 63);

        // R5: sync off keeps data clock idle
        div_k = 6'd1;
        per = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (dclk || bit_stb) per++;
        end
        chk("R5 idle clock", per, 0);

        // R2 R3: data clock periods and clamp of n
        sync_en = 1'b1;
        dclk_case(2, 0, 16);
        dclk_case(1, 2, 32);
        dclk_case(1, 5, 256);
        dclk_case(3, 7, 768);
        dclk_case(0, 1, 16);

        // R4 R7: synchronous capture with divider switching
        div_k = 6'd1; pow_n = 3'd0; mod_mode = 2'b10;
        for (int i = 0; i < 6; i++) begin
            logic b;
            b = (i == 0 || i == 2 || i == 3) ? 1'b1 : 1'b0;
            wait_fall();
            prev = tx_bit;
            data_in = b;
            @(negedge clk);
            chk("R4 hold before rise", tx_bit, prev);
            wait_rise();
            @(negedge clk);
            @(negedge clk);
            chk("R4 captured", tx_bit, b);
            chk("R7 follows bit", syn_m, b ? m1 : m0);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule